// File: doc/BRIEF.md
# Token Capture Transmit Sequencer

This block sits between a station's transmit requester and the outbound symbol path of a timed-token ring. The requester works in two separate steps. It first asks for the token. Once the block holds the token, the requester presents frame bytes through a valid/ready handshake. The block keeps the captured token for as long as an external holding timer reports it usable. While no frame data is waiting, it fills the ring with void frames, so the requester can take as long as it needs to prepare. When the token stops being usable, or the requester withdraws its request, the block finishes whatever is on the wire and then puts a token marker on the output.

Every requester byte carries an odd parity bit. A byte that fails the parity check ends the frame with an abort marker. The remaining bytes of that frame are consumed and dropped, and a sticky error flag is raised. The output is a byte stream with a control flag that separates marker symbols from data symbols. Marker values and the void frame's control byte are parameters.

Top module: `tok_tx_seq`

## Requirements
- R1: After reset, out_valid, granted, tx_ready and par_err are all 0.
- R2: With req_token high, the block leaves idle. A tok_arrive pulse while it is waiting captures the token, and granted then goes high. A tok_arrive pulse while idle is ignored.
- R3: Dropping req_token while waiting for a token returns the block to idle. This produces no output symbol and granted stays 0. If withdrawal and tok_arrive occur in the same cycle, the withdrawal wins.
- R4: While the token is held and no frame data is offered, the output repeats a 4-symbol void frame: start marker 0xC8 (ctl=1), frame-control byte 0x40 (ctl=0), then two end markers 0xD4 (ctl=1).
- R5: tx_ready is high only while the token is held and frame bytes are being taken. Accepted bytes appear with ctl=0 in acceptance order. They are preceded by one start marker and followed by two end markers.
- R6: A data frame starts only on a void-frame boundary. Every void frame on the output is complete.
- R7: When token_usable falls while void frames are being sent, the current void frame completes. A token marker 0xE7 (ctl=1) follows, and granted falls.
- R8: When token_usable falls during a data frame, that frame completes with its end markers and the token marker follows. No new frame starts, even if tx_valid stays high.
- R9: When req_token falls while the token is held, the token marker is issued after the current void or data frame.
- R10: A byte whose 8 data bits plus parity bit hold an even number of ones is replaced by abort marker 0xA1 (ctl=1), which ends the frame. The frame's remaining bytes are accepted and dropped up to and including the one flagged last. par_err is set and stays set until reset.
- R11: Every output symbol other than the token marker is emitted while the token is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_token | input | 1 | Requester asks for, and keeps asking to hold, the token |
| tok_arrive | input | 1 | A token is passing and can be captured |
| token_usable | input | 1 | Holding timer reports the held token still usable |
| tx_valid | input | 1 | Requester offers a frame byte |
| tx_data | input | 8 | Frame byte |
| tx_par | input | 1 | Odd parity bit over tx_data |
| tx_last | input | 1 | Offered byte is the last byte of the frame |
| tx_ready | output | 1 | Block takes the offered byte this cycle |
| granted | output | 1 | Token is held |
| out_valid | output | 1 | Output symbol valid |
| out_ctl | output | 1 | Output symbol is a marker (1) or data (0) |
| out_byte | output | 8 | Output symbol value |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The hardest situations to reach are a token loss that lands inside a data frame while the requester already has the next frame waiting, and a parity error on a byte that is not the last of its frame. The first needs token_usable dropped a cycle after a given byte is accepted, with tx_valid kept high afterwards. The second needs the drain phase to swallow the tail of the frame. Directed sessions set up both cases: the requester offers its first byte before the token arrives, which pins the frame to the first boundary, and the drop is tied to a chosen byte index. Random sessions then vary frame lengths, handshake gaps, idle spans, the release cause and the corrupted byte. The output stream is checked after void frames are stripped out.

// File: rtl/tok_tx_pkg.sv
package tok_tx_pkg;

  localparam int SYM_W    = 8;
  localparam int VOID_LEN = 4;
  localparam int VC_W     = $clog2(VOID_LEN);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD,
    ST_SEND,
    ST_ISSUE
  } tx_state_e;

  typedef enum logic [1:0] {
    PH_DATA,
    PH_END1,
    PH_END2,
    PH_DRAIN
  } send_ph_e;

endpackage

// File: rtl/tok_tx_rst_sync.sv
module tok_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tok_tx_parity.sv
module tok_tx_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         par,
  output logic         par_ok
);

  // odd parity: data plus parity bit carry an odd count of ones
  assign par_ok = ^{data, par};

endmodule

// File: rtl/tok_tx_fsm.sv
module tok_tx_fsm
  import tok_tx_pkg::*;
#(
  parameter int           W       = SYM_W,
  parameter logic [W-1:0] C_START = 8'hC8,
  parameter logic [W-1:0] C_END   = 8'hD4,
  parameter logic [W-1:0] C_ABORT = 8'hA1,
  parameter logic [W-1:0] C_TOKEN = 8'hE7,
  parameter logic [W-1:0] VOID_FC = 8'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_token,
  input  logic         tok_arrive,
  input  logic         token_usable,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  input  logic         par_ok,
  output logic         tx_ready,
  output logic         granted,
  output logic         emit_vld,
  output logic         emit_ctl,
  output logic [W-1:0] emit_byte,
  output logic         err_set
);

  tx_state_e       st_q, st_n;
  send_ph_e        ph_q, ph_n;
  logic [VC_W-1:0] vc_q, vc_n;
  logic            take;

  assign tx_ready = (st_q == ST_SEND) && ((ph_q == PH_DATA) || (ph_q == PH_DRAIN));
  assign granted  = (st_q == ST_HOLD) || (st_q == ST_SEND);
  assign take     = tx_ready && tx_valid;

  always_comb begin
    st_n      = st_q;
    ph_n      = ph_q;
    vc_n      = vc_q;
    emit_vld  = 1'b0;
    emit_ctl  = 1'b0;
    emit_byte = '0;
    err_set   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_token) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (!req_token)      st_n = ST_IDLE;
        else if (tok_arrive) st_n = ST_HOLD;
      end
      ST_HOLD: begin
        if (vc_q == '0) begin
          if (!token_usable || !req_token) begin
            st_n = ST_ISSUE;
          end else begin
            emit_vld  = 1'b1;
            emit_ctl  = 1'b1;
            emit_byte = C_START;
            if (tx_valid) begin
              st_n = ST_SEND;
              ph_n = PH_DATA;
            end else begin
              vc_n = vc_q + 1'b1;
            end
          end
        end else begin
          emit_vld = 1'b1;
          if (vc_q == VC_W'(1)) begin
            emit_ctl  = 1'b0;
            emit_byte = VOID_FC;
          end else begin
            emit_ctl  = 1'b1;
            emit_byte = C_END;
          end
          vc_n = (vc_q == VC_W'(VOID_LEN - 1)) ? '0 : vc_q + 1'b1;
        end
      end
      ST_SEND: begin
        unique case (ph_q)
          PH_DATA: begin
            if (take) begin
              emit_vld = 1'b1;
              if (!par_ok) begin
                emit_ctl  = 1'b1;
                emit_byte = C_ABORT;
                err_set   = 1'b1;
                if (tx_last) begin
                  st_n = ST_HOLD;
                  vc_n = '0;
                end else begin
                  ph_n = PH_DRAIN;
                end
              end else begin
                emit_ctl  = 1'b0;
                emit_byte = tx_data;
                if (tx_last) ph_n = PH_END1;
              end
            end
          end
          PH_END1: begin
            emit_vld  = 1'b1;
            emit_ctl  = 1'b1;
            emit_byte = C_END;
            ph_n      = PH_END2;
          end
          PH_END2: begin
            emit_vld  = 1'b1;
            emit_ctl  = 1'b1;
            emit_byte = C_END;
            st_n      = ST_HOLD;
            ph_n      = PH_DATA;
            vc_n      = '0;
          end
          PH_DRAIN: begin
            if (take && tx_last) begin
              st_n = ST_HOLD;
              ph_n = PH_DATA;
              vc_n = '0;
            end
          end
          default: ph_n = PH_DATA;
        endcase
      end
      ST_ISSUE: begin
        emit_vld  = 1'b1;
        emit_ctl  = 1'b1;
        emit_byte = C_TOKEN;
        st_n      = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= PH_DATA;
      vc_q <= '0;
    end else begin
      st_q <= st_n;
      ph_q <= ph_n;
      vc_q <= vc_n;
    end
  end

endmodule

// File: rtl/tok_tx_outreg.sv
module tok_tx_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emit_vld,
  input  logic         emit_ctl,
  input  logic [W-1:0] emit_byte,
  input  logic         err_set,
  output logic         out_valid,
  output logic         out_ctl,
  output logic [W-1:0] out_byte,
  output logic         par_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ctl   <= 1'b0;
      out_byte  <= '0;
      par_err   <= 1'b0;
    end else begin
      out_valid <= emit_vld;
      if (emit_vld) begin
        out_ctl  <= emit_ctl;
        out_byte <= emit_byte;
      end
      if (err_set) begin
        par_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tok_tx_seq.sv
module tok_tx_seq
  import tok_tx_pkg::*;
#(
  parameter int               W          = SYM_W,
  parameter int               RST_STAGES = 2,
  parameter logic [SYM_W-1:0] C_START    = 8'hC8,
  parameter logic [SYM_W-1:0] C_END      = 8'hD4,
  parameter logic [SYM_W-1:0] C_ABORT    = 8'hA1,
  parameter logic [SYM_W-1:0] C_TOKEN    = 8'hE7,
  parameter logic [SYM_W-1:0] VOID_FC    = 8'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_token,
  input  logic         tok_arrive,
  input  logic         token_usable,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  input  logic         tx_par,
  input  logic         tx_last,
  output logic         tx_ready,
  output logic         granted,
  output logic         out_valid,
  output logic         out_ctl,
  output logic [W-1:0] out_byte,
  output logic         par_err
);

  logic         rst_n_i;
  logic         par_ok;
  logic         emit_vld;
  logic         emit_ctl;
  logic [W-1:0] emit_byte;
  logic         err_set;

  tok_tx_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  tok_tx_parity #(.W(W)) par_i (
    .data   (tx_data),
    .par    (tx_par),
    .par_ok (par_ok)
  );

  tok_tx_fsm #(
    .W(W), .C_START(C_START), .C_END(C_END), .C_ABORT(C_ABORT),
    .C_TOKEN(C_TOKEN), .VOID_FC(VOID_FC)
  ) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .req_token    (req_token),
    .tok_arrive   (tok_arrive),
    .token_usable (token_usable),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .par_ok       (par_ok),
    .tx_ready     (tx_ready),
    .granted      (granted),
    .emit_vld     (emit_vld),
    .emit_ctl     (emit_ctl),
    .emit_byte    (emit_byte),
    .err_set      (err_set)
  );

  tok_tx_outreg #(.W(W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .emit_vld  (emit_vld),
    .emit_ctl  (emit_ctl),
    .emit_byte (emit_byte),
    .err_set   (err_set),
    .out_valid (out_valid),
    .out_ctl   (out_ctl),
    .out_byte  (out_byte),
    .par_err   (par_err)
  );

endmodule

// File: rtl/tok_tx_seq_chk.sv
module tok_tx_seq_chk #(
  parameter int         W       = 8,
  parameter logic [W-1:0] C_END   = 8'hD4,
  parameter logic [W-1:0] C_ABORT = 8'hA1,
  parameter logic [W-1:0] C_TOKEN = 8'hE7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_ready,
  input logic         granted,
  input logic         out_valid,
  input logic         out_ctl,
  input logic [W-1:0] out_byte,
  input logic         par_err
);

  logic is_end, is_tok, is_abort;
  assign is_end   = out_valid && out_ctl && (out_byte == C_END);
  assign is_tok   = out_valid && out_ctl && (out_byte == C_TOKEN);
  assign is_abort = out_valid && out_ctl && (out_byte == C_ABORT);

  // R5: bytes are only taken while the token is held
  p_ready_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> granted);

  // R10: error flag never clears once set
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err);

  // R10: an abort marker on the wire comes with the error flag
  p_abort_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_abort |-> par_err);

  // R7: the token marker appears once the token is no longer held
  p_token_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_tok |-> !granted);

  // R11: non-token symbols come from a held-token cycle
  p_emit_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_tok) |-> $past(granted));

  // R4: end markers come in pairs
  p_end_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_end && !$past(is_end)) |=> is_end);

endmodule

bind tok_tx_seq tok_tx_seq_chk #(
  .W(W), .C_END(C_END), .C_ABORT(C_ABORT), .C_TOKEN(C_TOKEN)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_ready  (tx_ready),
  .granted   (granted),
  .out_valid (out_valid),
  .out_ctl   (out_ctl),
  .out_byte  (out_byte),
  .par_err   (par_err)
);

// File: tb/tok_tx_seq_tb_top.sv
module tok_tx_seq_tb_top;

  localparam logic [7:0] S_START = 8'hC8;
  localparam logic [7:0] S_END   = 8'hD4;
  localparam logic [7:0] S_ABORT = 8'hA1;
  localparam logic [7:0] S_TOKEN = 8'hE7;
  localparam logic [7:0] S_FC    = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_token, tok_arrive, token_usable;
  logic       tx_valid, tx_par, tx_last;
  logic [7:0] tx_data;
  logic       tx_ready, granted, out_valid, out_ctl, par_err;
  logic [7:0] out_byte;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  int ready_seen = 0;
  bit err_exp = 0;

  logic [8:0] cap[$];
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  tok_tx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_token(req_token), .tok_arrive(tok_arrive),
    .token_usable(token_usable), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_par(tx_par), .tx_last(tx_last), .tx_ready(tx_ready), .granted(granted),
    .out_valid(out_valid), .out_ctl(out_ctl), .out_byte(out_byte), .par_err(par_err)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid) cap.push_back({out_ctl, out_byte});
    if (tx_ready) ready_seen++;
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, 150000);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  function automatic logic [7:0] rnd_data();
    logic [7:0] d = 8'($urandom % 256);
    if (d == S_FC) d = 8'h41;
    return d;
  endfunction

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_grant(input logic v);
    for (int k = 0; k < 400; k++) begin
      if (granted == v) break;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_token = 0; tok_arrive = 0; token_usable = 1;
    tx_valid = 0; tx_data = 0; tx_par = 0; tx_last = 0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    cap.delete();
    err_exp = 0;
  endtask

  // sends one frame, builds its expected symbols; drop_at>=0 clears token_usable
  task automatic send_frame(input int n, input int bad, input bit gaps, input int drop_at);
    bit aborted = 0;
    exp_q.push_back({1'b1, S_START});
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = rnd_data();
      tx_valid = 1; tx_data = d; tx_last = (k == n - 1);
      tx_par = (k == bad) ? ~odd_par(d) : odd_par(d);
      for (int t = 0; t < 2000; t++) begin
        #1;
        if (tx_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      if (!aborted) begin
        if (k == bad) begin
          aborted = 1;
          exp_q.push_back({1'b1, S_ABORT});
          err_exp = 1;
        end else begin
          exp_q.push_back({1'b0, d});
        end
      end
      if (k == drop_at) token_usable = 0;
      if (gaps && k != n - 1 && ($urandom % 3 == 0)) begin
        tx_valid = 0;
        cycles(1 + $urandom % 3);
      end
    end
    tx_valid = 0; tx_last = 0;
    if (!aborted) begin
      exp_q.push_back({1'b1, S_END});
      exp_q.push_back({1'b1, S_END});
    end
  endtask

  // strip void frames, then compare with expected (R5, R6, R7, R9)
  task automatic check_stream(input string req);
    logic [8:0] filt[$];
    int bad_void = 0;
    int i = 0;
    int mism = -1;
    while (i < cap.size()) begin
      if (cap[i] == {1'b1, S_START} && i + 1 < cap.size() && cap[i+1] == {1'b0, S_FC}) begin
        if (!(i + 3 < cap.size() && cap[i+2] == {1'b1, S_END} && cap[i+3] == {1'b1, S_END}))
          bad_void++;
        i += 4;
      end else begin
        filt.push_back(cap[i]);
        i++;
      end
    end
    chk(bad_void == 0, "R6", "incomplete void frames", bad_void, 0);
    chk(filt.size() == exp_q.size(), req, "stream length", filt.size(), exp_q.size());
    for (int k = 0; k < filt.size() && k < exp_q.size(); k++)
      if (filt[k] != exp_q[k] && mism < 0) mism = k;
    chk(mism < 0, req, "stream symbol",
        (mism < 0) ? 0 : int'(filt[mism]), (mism < 0) ? 0 : int'(exp_q[mism]));
  endtask

  task automatic grab_token();
    req_token = 1;
    cycles(1 + $urandom % 3);
    tok_arrive = 1;
    cycles(1);
    tok_arrive = 0;
    wait_grant(1'b1);
  endtask

  task automatic session(input int nfr, input int bad_frame, input bit by_withdraw,
                         input bit gaps);
    cap.delete(); exp_q.delete();
    token_usable = 1;
    grab_token();
    chk(granted == 1, "R2", "granted after capture", granted, 1);
    cycles($urandom % 13);
    for (int f = 0; f < nfr; f++) begin
      int n = 1 + $urandom % 6;
      send_frame(n, (f == bad_frame) ? int'($urandom % n) : -1, gaps, -1);
      cycles($urandom % 9);
    end
    if (by_withdraw) req_token = 0;   // R9
    else token_usable = 0;            // R7
    wait_grant(1'b0);
    cycles(3);
    exp_q.push_back({1'b1, S_TOKEN});
    check_stream(by_withdraw ? "R9" : "R7");
    chk(par_err == err_exp, "R10", "par_err level", par_err, err_exp);
    req_token = 0; token_usable = 1;
    cycles(2);
  endtask

  initial begin
    void'($urandom(32'h5EED_7A1C));
    do_reset();

    // R1: reset state
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(granted == 0, "R1", "granted", granted, 0);
    chk(tx_ready == 0, "R1", "tx_ready", tx_ready, 0);
    chk(par_err == 0, "R1", "par_err", par_err, 0);

    // R2: token pulse while idle ignored
    tok_arrive = 1; cycles(1); tok_arrive = 0; cycles(3);
    chk(granted == 0, "R2", "idle token ignored", granted, 0);

    // R3: withdraw while waiting, coinciding with a token
    req_token = 1; cycles(2);
    req_token = 0; tok_arrive = 1; cycles(1); tok_arrive = 0; cycles(5);
    chk(granted == 0, "R3", "granted after withdrawal", granted, 0);
    chk(cap.size() == 0, "R3", "symbols emitted", cap.size(), 0);

    // R4: exact void frame content, ended by withdrawal
    cap.delete(); exp_q.delete();
    grab_token();
    cycles(10);
    begin
      logic [8:0] v[4] = '{{1'b1, S_START}, {1'b0, S_FC}, {1'b1, S_END}, {1'b1, S_END}};
      int bad = 0;
      for (int k = 0; k < 8; k++) if (k >= cap.size() || cap[k] != v[k % 4]) bad++;
      chk(bad == 0, "R4", "void symbols wrong", bad, 0);
    end
    req_token = 0;
    wait_grant(1'b0); cycles(3);
    exp_q.push_back({1'b1, S_TOKEN});
    check_stream("R9");
    token_usable = 1; cycles(2);

    // R8: token lost inside a data frame, next frame pending
    cap.delete(); exp_q.delete();
    tx_valid = 1; tx_data = 8'h11; tx_par = odd_par(8'h11); tx_last = 0;
    grab_token();
    send_frame(4, -1, 0, 1);
    tx_valid = 1; tx_data = 8'h22; tx_par = odd_par(8'h22); tx_last = 1;
    ready_seen = 0;
    cycles(20);
    chk(ready_seen == 0, "R8", "ready cycles after release", ready_seen, 0);
    chk(granted == 0, "R8", "granted after release", granted, 0);
    exp_q.push_back({1'b1, S_TOKEN});
    chk(cap.size() == exp_q.size(), "R8", "symbol count", cap.size(), exp_q.size());
    check_stream("R8");
    tx_valid = 0; tx_last = 0; req_token = 0; token_usable = 1; cycles(2);

    // R10: parity error in a mid-frame byte, then sticky across a clean session
    cap.delete(); exp_q.delete();
    grab_token();
    exp_q.push_back({1'b1, S_START});
    for (int k = 0; k < 5; k++) begin
      logic [7:0] d = 8'h30 + 8'(k);
      tx_valid = 1; tx_data = d; tx_last = (k == 4);
      tx_par = (k == 1) ? ~odd_par(d) : odd_par(d);
      for (int t = 0; t < 200; t++) begin
        #1;
        if (tx_ready) begin @(negedge clk); break; end
        @(negedge clk);
      end
      if (k == 0) exp_q.push_back({1'b0, d});
      if (k == 1) exp_q.push_back({1'b1, S_ABORT});
    end
    tx_valid = 0; tx_last = 0;
    err_exp = 1;
    cycles(6);
    chk(par_err == 1, "R10", "par_err after bad byte", par_err, 1);
    token_usable = 0; wait_grant(1'b0); cycles(3);
    exp_q.push_back({1'b1, S_TOKEN});
    check_stream("R10");
    req_token = 0; token_usable = 1; cycles(2);
    session(2, -1, 0, 1);
    chk(par_err == 1, "R10", "par_err sticky", par_err, 1);
    do_reset();
    chk(par_err == 0, "R1", "par_err cleared by reset", par_err, 0);

    // random sessions: R5, R6, R7, R9, R10, R11
    for (int s = 0; s < 40; s++) begin
      int bf = ($urandom % 5 == 0) ? int'($urandom % 3) : -1;
      session(1 + $urandom % 3, bf, 1'($urandom % 2), 1'($urandom % 2));
    end

    report();
  end

endmodule